// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the addresses of a four-beat burst. An external address is captured by one of two active-low address strobes. From then on only the two lowest address bits move, and the upper bits keep the captured value until the next capture. Each cycle the sequence either steps to the next beat or waits on the current one, as the advance input directs.

A static order-select input picks between two beat orders. In the interleaved order, each beat's low bits are the starting low bits XOR the beat number. In the linear order, the low bits count up modulo 4 from the start. An internal 2-bit beat number drives both orders. It is cleared on every capture and steps on every advance, so after four advances the burst wraps back to its starting address.

The block is used as the address front end of a burst-capable memory. It sits between the bus control signals and the array decoder, and also reports the beat number of the current address.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous active-high reset drives `addr_out` and `beat_idx` to zero on the next rising edge.
- R2: When `strobe_p_n` is low and `sel_n` is low at a rising edge, `addr_out` takes the value of `addr_in` and `beat_idx` becomes 0.
- R3: When `strobe_p_n` is low, `sel_n` is high and `strobe_c_n` is high, no capture happens. The state follows the advance rule instead.
- R4: When `strobe_c_n` is low, a capture happens whatever the level of `sel_n`.
- R5: A capture takes priority over advancing: with a capture and `adv_n` low in the same cycle, `beat_idx` is 0 afterwards.
- R6: With no capture and `adv_n` low, `beat_idx` steps by one modulo 4 on each rising edge.
- R7: With no capture and `adv_n` high, `addr_out` and `beat_idx` keep their values (a wait cycle).
- R8: With `seq_mode` = 1 (interleaved), `addr_out[1:0]` equals the captured low bits XOR `beat_idx`. A start of 01 gives 01, 00, 11, 10, and a start of 10 gives 10, 11, 00, 01.
- R9: With `seq_mode` = 0 (linear), `addr_out[1:0]` equals the captured low bits plus `beat_idx`, modulo 4. A start of 01 gives 01, 10, 11, 00, and a start of 11 gives 11, 00, 01, 10.
- R10: `addr_out[ADDR_W-1:2]` keeps its value on every edge without a capture or reset.
- R11: After four advances following a capture, `addr_out` returns to the captured address and `beat_idx` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | External address to capture |
| strobe_p_n | input | 1 | Address strobe, active low, qualified by `sel_n` |
| strobe_c_n | input | 1 | Address strobe, active low, unqualified |
| sel_n | input | 1 | Select, active low, gates `strobe_p_n` |
| adv_n | input | 1 | Advance to the next beat, active low |
| seq_mode | input | 1 | Static order select: 1 interleaved, 0 linear |
| addr_out | output | ADDR_W | Current burst address |
| beat_idx | output | 2 | Beat number of the current address |

## Verification
A wrong start-bits or beat register shows up at `addr_out[1:0]` on the first edge after the fault. A missed or extra step also shows as a `beat_idx` that no longer counts the advances since the capture. A corrupted upper register appears at once in `addr_out[ADDR_W-1:2]` during a wait or an advance. In every case the fault is visible one cycle after the edge that caused it. The directed bursts compare every beat against an independently computed order, so an error is caught within the same burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef logic [1:0] beat_t;

    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } order_e;

    function automatic beat_t beat_step(input beat_t b);
        return b + 2'd1;
    endfunction

endpackage

// File: rtl/burst_load_qual.sv
module burst_load_qual (
    input  logic strobe_p_n,
    input  logic strobe_c_n,
    input  logic sel_n,
    output logic load
);
    logic ld_proc;
    logic ld_ctrl;

    always_comb begin
        ld_proc = ~strobe_p_n & ~sel_n;
        ld_ctrl = ~strobe_c_n;
        load    = ld_proc | ld_ctrl;
    end
endmodule

// File: rtl/burst_lo_map.sv
module burst_lo_map
    import burst_seq_pkg::*;
(
    input  beat_t  start_lo,
    input  beat_t  beat,
    input  logic   seq_mode,
    output beat_t  lo
);
    beat_t lo_xor;
    beat_t lo_lin;

    always_comb begin
        lo_xor = start_lo ^ beat;
        lo_lin = start_lo + beat;
        lo     = (order_e'(seq_mode) == ORDER_XOR) ? lo_xor : lo_lin;
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strobe_p_n,
    input  logic              strobe_c_n,
    input  logic              sel_n,
    input  logic              adv_n,
    input  logic              seq_mode,
    output logic [ADDR_W-1:0] addr_out,
    output logic [1:0]        beat_idx
);
    localparam int HI_W = ADDR_W - 2;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        beat_t           start_lo;
        beat_t           beat;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       load;
    beat_t      lo_cur;

    burst_load_qual u_qual (
        .strobe_p_n (strobe_p_n),
        .strobe_c_n (strobe_c_n),
        .sel_n      (sel_n),
        .load       (load)
    );

    burst_lo_map u_map (
        .start_lo (st_q.start_lo),
        .beat     (st_q.beat),
        .seq_mode (seq_mode),
        .lo       (lo_cur)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else if (load) begin
            st_d.hi       = addr_in[ADDR_W-1:2];
            st_d.start_lo = addr_in[1:0];
            st_d.beat     = '0;
        end else if (!adv_n) begin
            st_d.beat = beat_step(st_q.beat);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign addr_out = {st_q.hi, lo_cur};
    assign beat_idx = st_q.beat;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_in,
    input logic              strobe_p_n,
    input logic              strobe_c_n,
    input logic              sel_n,
    input logic              adv_n,
    input logic              seq_mode,
    input logic [ADDR_W-1:0] addr_out,
    input logic [1:0]        beat_idx
);
    logic cap;
    assign cap = (!strobe_p_n && !sel_n) || !strobe_c_n;

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (addr_out == '0 && beat_idx == 2'd0));

    // R2, R4, R5: capture loads the address and clears the beat number
    assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
        cap |=> (addr_out == $past(addr_in) && beat_idx == 2'd0));

    assert_uncaptured_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        (!strobe_p_n && sel_n && strobe_c_n && !adv_n) |=> beat_idx == $past(beat_idx) + 2'd1);

    assert_advance_step_R6: assert property (@(posedge clk) disable iff (rst)
        (!cap && !adv_n) |=> beat_idx == $past(beat_idx) + 2'd1);

    assert_wait_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!cap && adv_n && $stable(seq_mode)) |=> ($stable(addr_out) && $stable(beat_idx)));

    assert_xor_order_R8: assert property (@(posedge clk) disable iff (rst)
        (!cap && !adv_n && seq_mode) |=>
            ((addr_out[1:0] ^ $past(addr_out[1:0])) == (beat_idx ^ $past(beat_idx))));

    assert_linear_order_R9: assert property (@(posedge clk) disable iff (rst)
        (!cap && !adv_n && !seq_mode) |=> addr_out[1:0] == $past(addr_out[1:0]) + 2'd1);

    assert_upper_fixed_R10: assert property (@(posedge clk) disable iff (rst)
        !cap |=> addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2]));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr_in    (addr_in),
    .strobe_p_n (strobe_p_n),
    .strobe_c_n (strobe_c_n),
    .sel_n      (sel_n),
    .adv_n      (adv_n),
    .seq_mode   (seq_mode),
    .addr_out   (addr_out),
    .beat_idx   (beat_idx)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
    localparam int ADDR_W = 17;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr_in = '0;
    logic              strobe_p_n = 1'b1;
    logic              strobe_c_n = 1'b1;
    logic              sel_n = 1'b1;
    logic              adv_n = 1'b1;
    logic              seq_mode = 1'b1;
    logic [ADDR_W-1:0] addr_out;
    logic [1:0]        beat_idx;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .addr_in(addr_in), .strobe_p_n(strobe_p_n),
        .strobe_c_n(strobe_c_n), .sel_n(sel_n), .adv_n(adv_n),
        .seq_mode(seq_mode), .addr_out(addr_out), .beat_idx(beat_idx)
    );

    function automatic logic [1:0] exp_lo(input logic [1:0] s, input logic [1:0] b, input logic m);
        return m ? (s ^ b) : (s + b);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        strobe_p_n = 1'b1; strobe_c_n = 1'b1; sel_n = 1'b1; adv_n = 1'b1;
    endtask

    task automatic check(input string req, input logic [ADDR_W-1:0] ea, input logic [1:0] eb);
        n_cmp++;
        if (addr_out !== ea || beat_idx !== eb) begin
            n_bad++;
            $display("FAIL %s: addr_out=%h beat_idx=%0d expected addr_out=%h beat_idx=%0d",
                     req, addr_out, beat_idx, ea, eb);
        end
    endtask

    // full burst: capture, then four advances, checking each beat and the wrap
    task automatic run_burst(input logic [ADDR_W-1:0] a, input logic m, input bit use_c, input string req);
        seq_mode = m;
        idle();
        addr_in = a;
        if (use_c) begin strobe_c_n = 1'b0; sel_n = 1'b1; end
        else       begin strobe_p_n = 1'b0; sel_n = 1'b0; end
        tick();
        idle();
        addr_in = ~a;
        check({req, " capture"}, a, 2'd0);
        for (int k = 1; k <= 4; k++) begin
            adv_n = 1'b0;
            tick();
            check(k == 4 ? "R11 wrap" : req,
                  {a[ADDR_W-1:2], exp_lo(a[1:0], 2'(k), m)}, 2'(k));
        end
        idle();
    endtask

    task automatic t_reset();
        rst = 1'b1; idle();
        tick(); tick();
        check("R1 reset", '0, 2'd0);
        rst = 1'b0;
    endtask

    task automatic t_wait();
        logic [ADDR_W-1:0] a = 17'h0B3E6;
        seq_mode = 1'b1; idle();
        addr_in = a; strobe_p_n = 1'b0; sel_n = 1'b0;
        tick(); idle();
        adv_n = 1'b0; tick();
        adv_n = 1'b1; addr_in = 17'h1FFFF;
        tick(); tick();
        check("R7 wait hold", {a[ADDR_W-1:2], exp_lo(a[1:0], 2'd1, 1'b1)}, 2'd1);
        check("R10 upper fixed", {a[ADDR_W-1:2], exp_lo(a[1:0], 2'd1, 1'b1)}, 2'd1);
    endtask

    task automatic t_unqualified();
        logic [ADDR_W-1:0] a = 17'h05550;
        seq_mode = 1'b0; idle();
        addr_in = a; strobe_c_n = 1'b0;
        tick(); idle();
        addr_in = 17'h1AAAB; strobe_p_n = 1'b0; sel_n = 1'b1; adv_n = 1'b0;
        tick(); idle();
        check("R3 unqualified strobe", {a[ADDR_W-1:2], exp_lo(a[1:0], 2'd1, 1'b0)}, 2'd1);
    endtask

    task automatic t_priority();
        logic [ADDR_W-1:0] a = 17'h12342;
        seq_mode = 1'b1; idle();
        adv_n = 1'b0; tick(); tick();
        addr_in = a; strobe_p_n = 1'b0; sel_n = 1'b0; adv_n = 1'b0;
        tick(); idle();
        check("R5 capture over advance", a, 2'd0);
    endtask

    task automatic t_reset_mid();
        seq_mode = 1'b0; idle();
        addr_in = 17'h0F0F3; strobe_c_n = 1'b0;
        tick(); idle(); adv_n = 1'b0; tick();
        rst = 1'b1; tick();
        rst = 1'b0; idle();
        check("R1 reset mid-burst", '0, 2'd0);
    endtask

    initial begin
        t_reset();
        run_burst(17'h1A5C1, 1'b1, 1'b0, "R8 xor start 01 R2 R6");
        run_burst(17'h0C3D2, 1'b1, 1'b0, "R8 xor start 10 R10");
        run_burst(17'h07E11, 1'b0, 1'b1, "R9 linear start 01 R4");
        run_burst(17'h1FFFF, 1'b0, 1'b1, "R9 linear start 11 R6");
        t_wait();
        t_unqualified();
        t_priority();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #20000;
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule